// File: doc/BRIEF.md
# Separable Three-Tap Box Blur Stream Filter

This block smooths a stream of unsigned 16-bit pixels that arrive in raster order, one per cycle, on a valid/ready input. It works in two stages. The row stage replaces each pixel with the integer mean of itself and its two horizontal neighbours. The column stage then takes the integer mean of three vertically adjacent row-stage results. Pixels whose window would leave the frame keep the value their stage received. The filtered stream leaves on a valid/ready output with a flag on the final pixel of each frame.

The row width is a build-time parameter. The number of rows is open-ended: the producer raises the input end-of-frame flag on the last pixel. After that pixel the block drains its line buffers before it accepts the next frame. The `two_pass` pin routes the filtered stream through a second identical filter, so the whole blur is applied twice. That pin may only change while the block is idle between frames.

Top module: `blur_box`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: For a column that is neither first nor last, the row stage gives floor((left + centre + right) / 3). The sum is taken at 18 bits, so inputs of 65535 do not wrap. In the first and last rows this value reaches the output unchanged.
- R3: In column 0 and column ROW_W-1, the row stage passes the pixel through unchanged.
- R4: For rows other than the first and last, the output is floor((above + centre + below) / 3) of the row-stage results. The first and last row of every frame, including a single-row frame, carry the row-stage result unchanged.
- R5: Output pixels leave in raster order, one per input pixel, with nothing dropped or repeated. `out_last` is 1 only on the final pixel of the frame. The cycle after that pixel is taken, `out_valid` is 0.
- R6: With `two_pass`=0, gap-free input and `out_ready` held at 1, each pixel leaves exactly ROW_W+4 cycles after it is accepted.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_pix` and `out_last` hold their values into the next cycle.
- R8: The cycle after the end-of-frame pixel is accepted, `in_ready` is 0. With `out_ready` held at 1, it stays 0 for exactly ROW_W+4 cycles. A following frame is filtered with no trace of the one before.
- R9: With `two_pass`=1, the output equals the filter applied twice over the frame. Under gap-free input and a ready sink, the latency is 2*(ROW_W+4)+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| two_pass | input | 1 | 1 applies the filter twice; change only while idle |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block takes the input pixel this cycle |
| in_pix | input | 16 | Input pixel value |
| in_last | input | 1 | Input pixel is the last of its frame |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Sink takes the output pixel this cycle |
| out_pix | output | 16 | Filtered pixel value |
| out_last | output | 1 | Output pixel is the last of its frame |

## Verification
Within one pass, each result is tied to a fixed count of pipeline steps, not to wall-clock cycles. A pixel accepted on one edge leaves ROW_W+4 steps later, and the end-of-frame pixel triggers exactly ROW_W+4 drain steps. The bench samples every port half a period after each edge. It records the edge of the first accepted pixel and the edge of the first valid output, and checks the gap against ROW_W+4 (or 2*(ROW_W+4)+1 with two passes) only in runs with no input gaps and no sink stalls. It counts the cycles with `in_ready` low after the end-of-frame pixel in those same runs. In runs with stalls, it checks values in order and only as each output is taken, so the check does not depend on timing.

// File: rtl/blur_pkg.sv
package blur_pkg;
  localparam int PIX_W = 16;
  localparam int SUM_W = PIX_W + 2;

  typedef logic [PIX_W-1:0] pix_t;

  // Mean of three pixels: wide sum, then truncating divide by three.
  function automatic pix_t avg3(input pix_t a, input pix_t b, input pix_t c);
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) + SUM_W'(b) + SUM_W'(c);
    return PIX_W'(s / SUM_W'(3));
  endfunction
endpackage

// File: rtl/blur_linebuf.sv
// Fixed delay of DEPTH steps, written so that block RAM in read-first mode fits.
module blur_linebuf #(
  parameter int DEPTH = 2000,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (en) begin
      ptr <= (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      dout     <= mem[ptr];
      mem[ptr] <= din;
    end
  end
endmodule

// File: rtl/blur_hpass.sv
// Row stage: the centre is the previous pixel, the right neighbour is the pixel arriving now.
module blur_hpass
  import blur_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic take,
  input  pix_t din,
  input  logic edge_px,
  output pix_t tap
);
  pix_t cur, left, right;
  logic cur_edge;

  assign right = take ? din : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= '0;
      left     <= '0;
      cur_edge <= 1'b1;
      tap      <= '0;
    end else if (en) begin
      left     <= cur;
      cur      <= right;
      cur_edge <= take ? edge_px : 1'b1;
      tap      <= cur_edge ? cur : avg3(left, cur, right);
    end
  end
endmodule

// File: rtl/blur_pass.sv
// One full blur pass: row stage, two row buffers, column stage, frame control.
module blur_pass
  import blur_pkg::*;
#(
  parameter int ROW_W = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  pix_t in_pix,
  input  logic in_last,
  output logic out_valid,
  input  logic out_ready,
  output pix_t out_pix,
  output logic out_last
);
  localparam int LAT    = ROW_W + 4;
  localparam int SC_MAX = LAT + ROW_W;
  localparam int SCW    = $clog2(SC_MAX + 1);
  localparam int FCW    = $clog2(LAT);
  localparam int CW     = $clog2(ROW_W);
  localparam int TAIL   = LAT - ROW_W;

  logic           draining;
  logic [FCW-1:0] fc;
  logic [SCW-1:0] sc;
  logic [CW-1:0]  col;
  logic           step_ok, fire, adv, emit, row_top, row_bot, frame_end, edge_px;
  pix_t           h, hd1, hd2, near_q, far_q, ctr, vres;

  assign step_ok   = !out_valid || out_ready;
  assign in_ready  = step_ok && !draining;
  assign fire      = in_ready && in_valid;
  assign adv       = fire || (draining && step_ok);
  assign emit      = sc >= SCW'(LAT);
  assign row_top   = sc < SCW'(SC_MAX);
  assign row_bot   = draining && (fc >= FCW'(TAIL));
  assign frame_end = draining && (fc == FCW'(LAT - 1));
  assign edge_px   = (col == '0) || (col == CW'(ROW_W - 1));

  // Step counter for the frame, and the drain phase after the last pixel
  always_ff @(posedge clk) begin
    if (rst) begin
      draining <= 1'b0;
      fc       <= '0;
      sc       <= '0;
    end else if (adv) begin
      if (frame_end) begin
        draining <= 1'b0;
        fc       <= '0;
        sc       <= '0;
      end else begin
        if (fire && in_last) begin
          draining <= 1'b1;
          fc       <= '0;
        end else if (draining) begin
          fc <= fc + 1'b1;
        end
        if (sc != SCW'(SC_MAX)) sc <= sc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
    end else if (fire) begin
      col <= (in_last || col == CW'(ROW_W - 1)) ? '0 : col + 1'b1;
    end
  end

  blur_hpass u_row (
    .clk(clk), .rst(rst), .en(adv), .take(fire),
    .din(in_pix), .edge_px(edge_px), .tap(h)
  );

  blur_linebuf #(.DEPTH(ROW_W), .DW(PIX_W)) u_lb_near (
    .clk(clk), .rst(rst), .en(adv), .din(h), .dout(near_q)
  );

  blur_linebuf #(.DEPTH(ROW_W), .DW(PIX_W)) u_lb_far (
    .clk(clk), .rst(rst), .en(adv), .din(near_q), .dout(far_q)
  );

  // Align the row below and the centre row with the row above
  always_ff @(posedge clk) begin
    if (rst) begin
      hd1 <= '0;
      hd2 <= '0;
      ctr <= '0;
    end else if (adv) begin
      hd1 <= h;
      hd2 <= hd1;
      ctr <= near_q;
    end
  end

  assign vres = (row_top || row_bot) ? ctr : avg3(far_q, ctr, hd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_last  <= 1'b0;
    end else if (adv) begin
      out_valid <= emit;
      out_pix   <= vres;
      out_last  <= frame_end;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/blur_box.sv
module blur_box
  import blur_pkg::*;
#(
  parameter int ROW_W = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             two_pass,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_last
);
  logic a_ov, a_or, a_ol;
  pix_t a_op;
  logic b_iv, b_ir, b_ov, b_or, b_ol;
  pix_t b_op;

  assign b_iv = two_pass && a_ov;
  assign a_or = two_pass ? b_ir : out_ready;
  assign b_or = two_pass && out_ready;

  blur_pass #(.ROW_W(ROW_W)) u_first (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_last(in_last),
    .out_valid(a_ov), .out_ready(a_or), .out_pix(a_op), .out_last(a_ol)
  );

  blur_pass #(.ROW_W(ROW_W)) u_second (
    .clk(clk), .rst(rst),
    .in_valid(b_iv), .in_ready(b_ir), .in_pix(a_op), .in_last(a_ol),
    .out_valid(b_ov), .out_ready(b_or), .out_pix(b_op), .out_last(b_ol)
  );

  assign out_valid = two_pass ? b_ov : a_ov;
  assign out_pix   = two_pass ? b_op : a_op;
  assign out_last  = two_pass ? b_ol : a_ol;
endmodule

// File: rtl/blur_box_chk.sv
module blur_box_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_last,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_pix,
  input logic        out_last
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && in_ready));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_last)));

  // R8
  drain_block_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R5
  frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !out_valid);

  // R5
  last_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
endmodule

bind blur_box blur_box_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
  .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_last(out_last)
);

// File: tb/sim_blur_box.sv
`timescale 1ns/1ps
module sim_blur_box;
  localparam int W    = 16;
  localparam int LAT  = W + 4;
  localparam int MAXN = 8 * W;

  logic clk = 1'b0, rst = 1'b1, two_pass = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [15:0] in_pix = '0;
  logic in_ready, out_valid, out_last;
  logic [15:0] out_pix;

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errs = 0;
  bit done = 1'b0;
  int src[MAXN];
  int expv[MAXN];

  blur_box #(.ROW_W(W)) u0 (
    .clk(clk), .rst(rst), .two_pass(two_pass),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int rows, input int mode);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < W; c++)
        case (mode)
          0:       src[r*W+c] = int'($urandom_range(65535));
          1:       src[r*W+c] = 65535;
          default: src[r*W+c] = c * 4000 + r * 300;
        endcase
  endtask

  // Software model of one pass over expv
  task automatic pass_once(input int rows);
    int hb[MAXN];
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < W; c++) begin
        int i = r * W + c;
        hb[i] = (c == 0 || c == W - 1) ? expv[i] : (expv[i-1] + expv[i] + expv[i+1]) / 3;
      end
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < W; c++) begin
        int i = r * W + c;
        expv[i] = (r == 0 || r == rows - 1) ? hb[i] : (hb[i-W] + hb[i] + hb[i+W]) / 3;
      end
  endtask

  function automatic string tag(input bit dbl, input int i, input int rows);
    int c = i % W;
    int r = i / W;
    if (dbl) return "R9";
    if (c == 0 || c == W - 1) return "R3";
    if (r == 0 || r == rows - 1) return "R2";
    return "R4";
  endfunction

  task automatic run_frame(input int rows, input bit dbl, input int gap, input int stall,
                           input int lat_exp);
    int n = rows * W;
    int ni = 0, no = 0, t = 0, first_acc = -1, first_out = -1, drain = 0;
    bit eof_seen = 1'b0, held = 1'b0;
    int held_pix = 0;
    for (int i = 0; i < n; i++) expv[i] = src[i];
    pass_once(rows);
    if (dbl) pass_once(rows);
    @(negedge clk);
    two_pass = dbl;
    while (no < n && t < 4000) begin
      @(negedge clk);
      in_valid  = (ni < n) && (int'($urandom_range(99)) >= gap);
      if (ni < n) begin
        in_pix  = 16'(src[ni]);
        in_last = (ni == n - 1);
      end else begin
        in_pix  = '0;
        in_last = 1'b0;
      end
      out_ready = int'($urandom_range(99)) >= stall;
      #1;
      if (held) chk(out_valid && out_pix == 16'(held_pix), "R7", int'(out_pix), held_pix);
      held     = out_valid && !out_ready;
      held_pix = int'(out_pix);
      if (eof_seen && !in_ready) drain++;
      if (in_valid && in_ready) begin
        if (first_acc < 0) first_acc = cyc;
        if (ni == n - 1) eof_seen = 1'b1;
        ni++;
      end
      if (out_valid && first_out < 0) first_out = cyc;
      if (out_valid && out_ready) begin
        chk(int'(out_pix) == expv[no], tag(dbl, no, rows), int'(out_pix), expv[no]);
        chk(out_last == (no == n - 1), "R5", int'(out_last), int'(no == n - 1));
        no++;
      end
      t++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    in_last   = 1'b0;
    out_ready = 1'b1;
    chk(no == n, "R5", no, n);
    if (lat_exp > 0)
      chk(first_out - first_acc - 1 == lat_exp, dbl ? "R9" : "R6",
          first_out - first_acc - 1, lat_exp);
    if (stall == 0) chk(drain == LAT, "R8", drain, LAT);
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R5", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R1: reset state
    chk(!out_valid, "R1", int'(out_valid), 0);
    chk(in_ready, "R1", int'(in_ready), 1);
    rst = 1'b0;
    fill(4, 0); run_frame(4, 1'b0, 0, 0, LAT);
    fill(1, 0); run_frame(1, 1'b0, 0, 0, LAT);
    fill(2, 0); run_frame(2, 1'b0, 20, 0, 0);
    fill(5, 1); run_frame(5, 1'b0, 0, 0, LAT);
    fill(6, 0); run_frame(6, 1'b0, 30, 40, 0);
    fill(3, 2); run_frame(3, 1'b0, 0, 25, 0);
    fill(8, 0); run_frame(8, 1'b0, 10, 10, 0);
    fill(3, 0); run_frame(3, 1'b1, 0, 0, 2 * LAT + 1);
    fill(5, 0); run_frame(5, 1'b1, 25, 35, 0);
    fill(1, 1); run_frame(1, 1'b1, 0, 0, 2 * LAT + 1);
    fill(4, 2); run_frame(4, 1'b0, 0, 0, LAT);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule